// File: doc/BRIEF.md
# Two-Page-Size Set-Associative Translation Buffer

This block keeps recently used virtual-to-physical page translations so that most address translations finish without a page-table walk. One array holds translations for two page sizes: 4 KiB pages and 2 MiB pages. It has 128 sets of 4 ways, which is 512 entries. All small pages give a reach of 2 MiB. All huge pages give a reach of 1 GiB.

The lookup port is combinational. A virtual address presented in one cycle returns hit, physical address and page size in the same cycle. The block probes two sets in parallel:

- the set picked by the small-page number, which it searches for small entries;
- the set picked by the huge-page number, which it searches for huge entries.

On a miss the surrounding logic walks the page tables, which sit outside this block. It then installs the result through the fill port. A single invalidate input empties the whole buffer. Each set has a 3-bit tree pseudo-LRU that chooses the way to replace.

Top module: `huge_tlb`

## Requirements
- R1: While reset is held and after it is released, every entry is invalid. While no entry matches, or when `lu_en` is low, `lu_hit`, `lu_pa` and `lu_huge` are all zero.
- R2: A small entry hits in the same cycle as the lookup. On that hit, `lu_pa` equals the stored 28-bit frame followed by `lu_va[11:0]`, and `lu_huge` is 0.
- R3: A huge entry hits in the same cycle as the lookup. On that hit, `lu_pa` equals the low 19 bits of the stored frame followed by `lu_va[20:0]`, and `lu_huge` is 1.
- R4: Small entries are indexed by VA bits 18:12 and tagged by VA bits 47:19. An address with the same index but a different tag misses.
- R5: Huge entries are indexed by VA bits 27:21 and tagged by VA bits 47:28. A huge entry matches every address with equal bits 47:21, whatever bits 20:0 hold.
- R6: A fill writes into the lowest-numbered invalid way of its target set. The target set is picked by `fill_va[18:12]` when `fill_huge` is 0 and by `fill_va[27:21]` when it is 1.
- R7: A fill into a full set replaces the way named by the tree.
  - Tree bit 0 selects the pair: 0 for ways 0/1, 1 for ways 2/3.
  - Bit 1 selects within ways 0/1: 0 for way 0.
  - Bit 2 selects within ways 2/3: 0 for way 2.
  - The tree resets to 000.
- R8: A fill touches its way in the tree. A lookup hit touches the hit way, but only in cycles with no fill and no invalidate.
  - Touching way 0 sets bits 0 and 1.
  - Touching way 1 sets bit 0 and clears bit 1.
  - Touching way 2 clears bit 0 and sets bit 2.
  - Touching way 3 clears bits 0 and 2.
- R9: `inval_all` clears every valid bit in one cycle, and it overrides a fill in the same cycle. It leaves the trees unchanged.
- R10: Both sets are probed in parallel. If a small entry and a huge entry both match, the small entry is returned. Among matches of one size, the lowest way wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Clear all entries |
| lu_en | input | 1 | Lookup request |
| lu_va | input | 48 | Lookup virtual address |
| lu_hit | output | 1 | Lookup hit |
| lu_pa | output | 40 | Translated physical address |
| lu_huge | output | 1 | Hit was a 2 MiB page |
| fill_en | input | 1 | Install a translation |
| fill_va | input | 48 | Virtual address of the installed page |
| fill_huge | input | 1 | Installed page is 2 MiB |
| fill_pfn | input | 28 | Physical frame number (low 19 bits used for huge pages) |

## Verification
Some properties are checked by assertions on every cycle:
- an invalidate empties the whole buffer;
- a fill into a set with room adds exactly one valid entry;
- a fill into a full set keeps the entry count unchanged;
- the trees hold still when nothing touches them;
- the page-offset bits of a hit pass straight through.

Other behaviour only the bench scenarios can show, because it needs the history of fills and hits. This covers which way a full set evicts after a particular sequence of hits, the choice of small over huge on a double match, and how a huge entry answers addresses across its whole 2 MiB span.

// File: rtl/huge_tlb.sv
module huge_tlb #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int SETS   = 128,
  parameter int SM_OFF = 12,
  parameter int HG_OFF = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval_all,
  input  logic              lu_en,
  input  logic [VA_W-1:0]   lu_va,
  output logic              lu_hit,
  output logic [PA_W-1:0]   lu_pa,
  output logic              lu_huge,
  input  logic              fill_en,
  input  logic [VA_W-1:0]   fill_va,
  input  logic              fill_huge,
  input  logic [PA_W-SM_OFF-1:0] fill_pfn
);
  localparam int WAYS   = 4;
  localparam int IDX_W  = $clog2(SETS);
  localparam int STAG_W = VA_W - SM_OFF - IDX_W;
  localparam int HTAG_W = VA_W - HG_OFF - IDX_W;
  localparam int SFN_W  = PA_W - SM_OFF;
  localparam int HFN_W  = PA_W - HG_OFF;
  localparam int CNT_W  = $clog2(SETS*WAYS + 1);

  logic [SETS-1:0][WAYS-1:0] vld;
  logic [SETS-1:0][WAYS-1:0] pgh;
  logic [SETS-1:0][2:0]      tree;
  logic [STAG_W-1:0] tag [SETS][WAYS];
  logic [SFN_W-1:0]  pfn [SETS][WAYS];

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  wire [IDX_W-1:0]  s_idx = lu_va[SM_OFF +: IDX_W];
  wire [IDX_W-1:0]  h_idx = lu_va[HG_OFF +: IDX_W];
  wire [STAG_W-1:0] s_tag = lu_va[VA_W-1 -: STAG_W];
  wire [STAG_W-1:0] h_tag = STAG_W'(lu_va[VA_W-1 -: HTAG_W]);

  logic [WAYS-1:0] s_m, h_m;
  logic [1:0]      s_way, h_way;
  always_comb begin
    s_way = '0;
    h_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      s_m[w] = vld[s_idx][w] && !pgh[s_idx][w] && tag[s_idx][w] == s_tag;
      h_m[w] = vld[h_idx][w] &&  pgh[h_idx][w] && tag[h_idx][w] == h_tag;
      if (s_m[w]) s_way = 2'(w);
      if (h_m[w]) h_way = 2'(w);
    end
  end

  wire s_hit = |s_m;
  wire h_hit = |h_m;
  wire [PA_W-1:0] s_pa = {pfn[s_idx][s_way], lu_va[SM_OFF-1:0]};
  wire [PA_W-1:0] h_pa = {pfn[h_idx][h_way][HFN_W-1:0], lu_va[HG_OFF-1:0]};

  assign lu_hit  = lu_en && (s_hit || h_hit);
  assign lu_huge = lu_hit && !s_hit;
  assign lu_pa   = !lu_hit ? '0 : (s_hit ? s_pa : h_pa);

  wire [IDX_W-1:0]  u_idx = s_hit ? s_idx : h_idx;
  wire [1:0]        u_way = s_hit ? s_way : h_way;

  wire [IDX_W-1:0]  f_idx = fill_huge ? fill_va[HG_OFF +: IDX_W] : fill_va[SM_OFF +: IDX_W];
  wire [STAG_W-1:0] f_tag = fill_huge ? STAG_W'(fill_va[VA_W-1 -: HTAG_W]) : fill_va[VA_W-1 -: STAG_W];
  wire [SFN_W-1:0]  f_pfn = fill_huge ? SFN_W'(fill_pfn[HFN_W-1:0]) : fill_pfn;
  wire [2:0]        f_t   = tree[f_idx];
  wire              f_full = &vld[f_idx];
  wire [1:0]        f_vic = f_t[0] ? {1'b1, f_t[2]} : {1'b0, f_t[1]};

  logic [1:0] f_free;
  always_comb begin
    f_free = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld[f_idx][w]) f_free = 2'(w);
  end
  wire [1:0] f_way = f_full ? f_vic : f_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      tree <= '0;
    end else if (inval_all) begin
      vld <= '0;
    end else if (fill_en) begin
      vld[f_idx][f_way] <= 1'b1;
      tree[f_idx]       <= touch(f_t, f_way);
    end else if (lu_hit) begin
      tree[u_idx] <= touch(tree[u_idx], u_way);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fill_en && !inval_all) begin
      pgh[f_idx][f_way] <= fill_huge;
      tag[f_idx][f_way] <= f_tag;
      pfn[f_idx][f_way] <= f_pfn;
    end
  end

  wire [CNT_W-1:0] vcount = CNT_W'($countones(vld));

  // R9
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> vcount == '0);
  // R6
  fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !inval_all && !f_full |=> vcount == $past(vcount) + 1'b1);
  // R7
  fill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !inval_all && f_full |=> vcount == $past(vcount));
  // R8
  tree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en && !lu_hit |=> $stable(tree));
  // R2
  small_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit && !lu_huge |-> lu_pa[SM_OFF-1:0] == lu_va[SM_OFF-1:0]);
  // R3
  huge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit && lu_huge |-> lu_pa[HG_OFF-1:0] == lu_va[HG_OFF-1:0]);
  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_en |-> !lu_hit && lu_pa == '0 && !lu_huge);
endmodule

// File: tb/huge_tlb_test.sv
module huge_tlb_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        inval_all = 0;
  logic        lu_en = 0;
  logic [47:0] lu_va = '0;
  logic        lu_hit;
  logic [39:0] lu_pa;
  logic        lu_huge;
  logic        fill_en = 0;
  logic [47:0] fill_va = '0;
  logic        fill_huge = 0;
  logic [27:0] fill_pfn = '0;

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  huge_tlb uut (.clk(clk), .rst_n(rst_n), .inval_all(inval_all), .lu_en(lu_en), .lu_va(lu_va),
    .lu_hit(lu_hit), .lu_pa(lu_pa), .lu_huge(lu_huge), .fill_en(fill_en), .fill_va(fill_va),
    .fill_huge(fill_huge), .fill_pfn(fill_pfn));

  // Behavioural reference: entries remember the full page number.
  bit      mv [128][4];
  bit      mh [128][4];
  longint  mvpn [128][4];
  longint  mfr [128][4];
  int      root [128], lpair [128], rpair [128];

  task automatic predict(input logic [47:0] va, input bit en,
      output bit hit, output logic [39:0] pa, output bit huge, output int set, output int way);
    longint sv, hv;
    int si, hi;
    sv = longint'(va >> 12); hv = longint'(va >> 21);
    si = int'(sv % 128); hi = int'(hv % 128);
    hit = 0; pa = '0; huge = 0; set = 0; way = 0;
    if (!en) return;
    for (int w = 0; w < 4 && !hit; w++)
      if (mv[si][w] && !mh[si][w] && mvpn[si][w] == sv) begin
        hit = 1; set = si; way = w;
        pa = 40'((mfr[si][w] << 12) | longint'(va & 48'hfff));
      end
    for (int w = 0; w < 4 && !hit; w++)
      if (mv[hi][w] && mh[hi][w] && mvpn[hi][w] == hv) begin
        hit = 1; huge = 1; set = hi; way = w;
        pa = 40'(((mfr[hi][w] % (64'd1 << 19)) << 21) | longint'(va & 48'h1fffff));
      end
  endtask

  task automatic use_way(input int s, input int w);
    root[s] = (w < 2) ? 1 : 0;
    if (w == 0) lpair[s] = 1;
    if (w == 1) lpair[s] = 0;
    if (w == 2) rpair[s] = 1;
    if (w == 3) rpair[s] = 0;
  endtask

  always @(posedge clk) begin
    bit h, hg; logic [39:0] p; int s, w;
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired (R1..): actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    predict(lu_va, lu_en, h, p, hg, s, w);
    if (!rst_n) begin
      foreach (mv[i, j]) mv[i][j] = 0;
      foreach (root[i]) begin root[i] = 0; lpair[i] = 0; rpair[i] = 0; end
    end else if (inval_all) begin
      foreach (mv[i, j]) mv[i][j] = 0;
    end else if (fill_en) begin
      int fs, fw;
      longint vpn;
      vpn = fill_huge ? longint'(fill_va >> 21) : longint'(fill_va >> 12);
      fs = int'(vpn % 128);
      fw = -1;
      for (int k = 3; k >= 0; k--) if (!mv[fs][k]) fw = k;
      if (fw < 0) fw = root[fs] ? (rpair[fs] ? 3 : 2) : (lpair[fs] ? 1 : 0);
      mv[fs][fw] = 1; mh[fs][fw] = fill_huge; mvpn[fs][fw] = vpn;
      mfr[fs][fw] = fill_huge ? longint'(fill_pfn[18:0]) : longint'(fill_pfn);
      use_way(fs, fw);
    end else if (h) begin
      use_way(s, w);
    end
  end

  always @(negedge clk) begin
    bit h, hg; logic [39:0] p; int s, w;
    predict(lu_va, lu_en && rst_n, h, p, hg, s, w);
    checks++;
    if (lu_hit !== h || lu_pa !== p || lu_huge !== hg) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%b pa=%h huge=%b expected hit=%b pa=%h huge=%b",
        phase, lu_va, lu_hit, lu_pa, lu_huge, h, p, hg);
    end
  end

  task automatic drive(input bit le, input logic [47:0] lva, input bit fe,
      input logic [47:0] fva, input bit fh, input logic [27:0] fp, input bit inv);
    lu_en = le; lu_va = lva; fill_en = fe; fill_va = fva; fill_huge = fh; fill_pfn = fp;
    inval_all = inv;
    @(posedge clk); #1;
  endtask

  task automatic look(input logic [47:0] va);
    drive(1, va, 0, '0, 0, '0, 0);
  endtask

  task automatic fill(input logic [47:0] va, input bit h, input logic [27:0] p);
    drive(0, '0, 1, va, h, p, 0);
  endtask

  function automatic logic [47:0] sva(input int k, input int set, input int off);
    return (48'(k) << 19) | (48'(set) << 12) | 48'(off);
  endfunction

  initial begin
    // R1: reset state and idle outputs
    phase = "R1";
    repeat (3) begin @(posedge clk); #1; end
    drive(1, 48'h1234_5678_9abc, 0, '0, 0, '0, 0);
    rst_n = 1;
    look(48'h0000_0000_0000); look(48'hffff_ffff_ffff); drive(0, 48'h1000, 0, '0, 0, '0, 0);

    // R2: small page translation
    phase = "R2";
    fill(sva(3, 5, 0), 0, 28'hABCDEF1);
    look(sva(3, 5, 'h000)); look(sva(3, 5, 'hfff)); look(sva(3, 5, 'h5a5));

    // R4: same set, other tag misses
    phase = "R4";
    look(sva(4, 5, 'h123)); look(sva(3, 6, 'h123));

    // R3 and R5: huge page translation across its span
    phase = "R3";
    fill(48'h0012_3460_0000, 1, 28'h7654321);
    look(48'h0012_3460_0000); look(48'h0012_347f_ffff);
    phase = "R5";
    look(48'h0012_346a_b123); look(48'h0012_3480_0000); look(48'h0022_3460_0000);

    // R10: small and huge both map the same address
    phase = "R10";
    fill(48'h0012_3461_5000, 0, 28'h0000111);
    look(48'h0012_3461_5abc); look(48'h0012_3461_6abc);

    // R6: fills take lowest free way; R7/R8: victim follows tree
    phase = "R6";
    for (int k = 1; k <= 4; k++) fill(sva(k + 16, 9, 0), 0, 28'(k * 16));
    for (int k = 1; k <= 4; k++) look(sva(k + 16, 9, 'h10));
    phase = "R8";
    look(sva(17, 9, 0));
    drive(1, sva(19, 9, 0), 1, sva(30, 9, 0), 0, 28'h30, 0);
    phase = "R7";
    for (int k = 17; k <= 20; k++) look(sva(k, 9, 4));
    look(sva(30, 9, 4));
    fill(sva(31, 9, 0), 0, 28'h31);
    for (int k = 17; k <= 31; k++) look(sva(k, 9, 8));

    // R9: invalidate clears all and beats a fill
    phase = "R9";
    drive(1, sva(3, 5, 0), 0, '0, 0, '0, 1);
    look(sva(3, 5, 0)); look(48'h0012_3460_0000); look(sva(31, 9, 0));
    drive(0, '0, 1, sva(40, 2, 0), 0, 28'h40, 1);
    look(sva(40, 2, 0));
    fill(sva(41, 2, 0), 0, 28'h41);
    look(sva(41, 2, 0));

    // R7/R8 mixed traffic over a small address pool
    phase = "R7/R8 mix";
    for (int i = 0; i < 3000; i++) begin
      logic [47:0] va;
      va = (48'($urandom_range(0, 3)) << 28) | (48'($urandom_range(0, 5)) << 19) |
           (48'($urandom_range(0, 1)) << 12) | 48'($urandom_range(0, 4095));
      drive($urandom_range(0, 3) != 0, va, $urandom_range(0, 3) == 0,
            (48'($urandom_range(0, 3)) << 28) | (48'($urandom_range(0, 5)) << 19) |
            (48'($urandom_range(0, 1)) << 12),
            $urandom_range(0, 4) == 0, 28'($urandom()), $urandom_range(0, 299) == 0);
    end

    drive(0, '0, 0, '0, 0, '0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule